// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns a single PWM command into two gate enables for the two switches of a synchronous buck stage. The high-side enable follows the PWM level and the low-side enable follows its inverse. Every hand-over between the two passes through a dead-time wait, so the two enables are never on together. When the high side turns off, the wait adapts to the switch node. The low side is released once the node has been seen high and has then dropped below roughly 1 V. There is a fixed fallback if the node never rose, and a timeout if it never falls. When the low side turns off, the high side waits for a flag saying the low-side gate has discharged, and then waits a short fixed delay.

Three comparator flags reach the block asynchronously, and each passes through its own synchronizer. The PWM command is taken to be synchronous to the block clock. An active-low output-disable input and a supply-ready input gate both enables off within the same cycle. Once both are released, the controller starts from an all-off state and reaches either gate only through the normal dead-time path. All delays are parameters counted in clock cycles. The defaults are 15, 19 and 3 cycles, which at 100 MHz give 150 ns, 190 ns and 30 ns.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: While enabled and settled, `drvh_en` equals `pwm_in` and `drvl_en` equals its inverse. The high side turns on only after a cycle in which PWM was high and the low side was off; the low side turns on only after a cycle in which PWM was low and the high side was off.
- R2: While `od_n` is 0, both enables are 0 in the same cycle, combinationally, whatever the other inputs do.
- R3: While `supply_ok` is 0, both enables are 0 in the same cycle, and PWM activity has no effect on the outputs.
- R4: When PWM is sampled low while the high side is on, `drvh_en` drops at that clock edge, and `drvl_en` stays 0 during the wait that follows.
- R5: If the switch-node-high flag was registered during the wait and the below-1 V flag then reads 1, `drvl_en` rises 2 clock edges after the edge that first samples the raw below flag. This covers the two-stage synchronizer and the decision edge, and is bounded by the R7 timeout.
- R6: If no switch-node-high flag is seen by the last fallback cycle, `drvl_en` rises FALLBACK_CYC edges after the edge at which `drvh_en` fell (edge 1+FALLBACK_CYC, counting the falling edge as 1).
- R7: If the node was seen high but never drops below 1 V, `drvl_en` rises at edge 1+TIMEOUT_CYC.
- R8: When PWM is sampled high while the low side is on, `drvl_en` drops at that edge. `drvh_en` rises HS_DLY_CYC+1 edges after the edge that first samples the raw gate-discharged flag.
- R9: `drvh_en` and `drvl_en` are never 1 in the same cycle.
- R10: Reset, disable and lockout all leave both enables at 0. On release with PWM low, `drvl_en` rises at edge 1+FALLBACK_CYC. On release with PWM high, `drvh_en` rises through the R8 wait.
- R11: A PWM edge during either dead-time wait cancels it and starts the opposite wait. The gate that was pending is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command, synchronous to clk; 1 requests the high side |
| od_n | input | 1 | Output disable, active low |
| supply_ok | input | 1 | Supply-ready flag; 0 means lockout |
| sw_high | input | 1 | Async flag: switch node has risen |
| sw_below_1v | input | 1 | Async flag: switch node is below about 1 V |
| drvl_low | input | 1 | Async flag: low-side gate is below one sixth of supply |
| drvh_en | output | 1 | High-side gate enable |
| drvl_en | output | 1 | Low-side gate enable |

## Verification
A wrong wait state shows up at the ports as a release of the pending gate on the wrong clock edge. A lost seen-high mark moves the low-side turn-on from the adaptive edge to the fallback edge. A stale count shifts every later release. A missed cancel lets a pending gate rise after PWM has already reversed. The sweeps move the time of each flag across the whole wait and measure the exact edge on which each enable first rises, so any of these faults changes a measured edge within about twenty cycles of the PWM transition that exposed it.

// File: rtl/gdt_pkg.sv
// Shared types for the adaptive dead-time gate controller.
// Assumes nothing beyond a synthesizable enum encoding.
package gdt_pkg;

    // Controller state: one conducting state per switch, one wait state
    // per hand-over direction, and an all-off parking state.
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_HS     = 3'd1,
        ST_LS     = 3'd2,
        ST_HL_GAP = 3'd3,
        ST_LH_GAP = 3'd4
    } gdt_state_e;

    // Index of each flag inside the synchronized flag vector.
    localparam int FLG_SW_HIGH  = 0;
    localparam int FLG_SW_BELOW = 1;
    localparam int FLG_GATE_LOW = 2;
    localparam int FLG_COUNT    = 3;

endpackage

// File: rtl/gdt_sync.sv
// Multi-stage synchronizer for one asynchronous level flag.
// Assumes the flag is a slow level; STAGES >= 2. Output is 0 during reset.
module gdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gdt_timer.sv
// Saturating up-counter used to time the dead-time waits.
// Assumes clr has priority over adv; the count holds at all ones.
module gdt_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_TOP = '1;

    // Clear on request, otherwise advance until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv && (cnt != CNT_TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gdt_fsm.sv
// Sequencing state machine for the two gate enables.
// Assumes synchronized flags, pwm synchronous to clk, FIX >= 1,
// TMO >= FIX and HSD >= 1. Outputs are decoded from the state register.
module gdt_fsm
    import gdt_pkg::*;
#(
    parameter int FIX = 15,
    parameter int TMO = 19,
    parameter int HSD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm,
    input  logic sw_high_s,
    input  logic sw_below_s,
    input  logic gate_low_s,
    output logic hs_on,
    output logic ls_on
);

    localparam int MAXC = (TMO > FIX) ? ((TMO > HSD) ? TMO : HSD)
                                      : ((FIX > HSD) ? FIX : HSD);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FIX_LAST = CW'(FIX - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(TMO - 1);
    localparam logic [CW-1:0] HSD_LAST = CW'(HSD - 1);

    gdt_state_e    state_q;
    gdt_state_e    state_d;
    logic          seen_high_q;
    logic          armed_q;
    logic [CW-1:0] cnt;
    logic          leaving;
    logic          adv;
    logic          ls_release;
    logic          hs_release;
    logic          node_rose;

    assign node_rose  = seen_high_q | sw_high_s;
    assign ls_release = (seen_high_q && sw_below_s)
                     || (!node_rose && (cnt == FIX_LAST))
                     || (cnt == TMO_LAST);
    assign hs_release = (armed_q || gate_low_s) && (cnt == HSD_LAST);

    // Next-state selection; disable or lockout overrides everything.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = pwm ? ST_LH_GAP : ST_HL_GAP;
            ST_HS:     if (!pwm) state_d = ST_HL_GAP;
            ST_LS:     if (pwm) state_d = ST_LH_GAP;
            ST_HL_GAP: begin
                if (pwm)             state_d = ST_LH_GAP;
                else if (ls_release) state_d = ST_LS;
            end
            ST_LH_GAP: begin
                if (!pwm)            state_d = ST_HL_GAP;
                else if (hs_release) state_d = ST_HS;
            end
            default:   state_d = ST_OFF;
        endcase
        if (!enable) state_d = ST_OFF;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign leaving = (state_d != state_q);
    assign adv     = (state_q == ST_HL_GAP)
                  || ((state_q == ST_LH_GAP) && (armed_q || gate_low_s));

    // Remember that the node rose during the current high-to-low wait.
    always_ff @(posedge clk) begin
        if (!rst_n || leaving)          seen_high_q <= 1'b0;
        else if (state_q == ST_HL_GAP)  seen_high_q <= seen_high_q | sw_high_s;
    end

    // Remember that the low gate discharged during the low-to-high wait.
    always_ff @(posedge clk) begin
        if (!rst_n || leaving)          armed_q <= 1'b0;
        else if (state_q == ST_LH_GAP)  armed_q <= armed_q | gate_low_s;
    end

    gdt_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (leaving),
        .adv   (adv),
        .cnt   (cnt)
    );

    assign hs_on = (state_q == ST_HS);
    assign ls_on = (state_q == ST_LS);

endmodule

// File: rtl/gate_deadtime_ctrl.sv
// Top level: synchronizes the comparator flags, runs the sequencer and
// gates both enables with output-disable and supply-ready.
// Assumes pwm_in is synchronous to clk; od_n and supply_ok may be async
// since they only force outputs off.
module gate_deadtime_ctrl
    import gdt_pkg::*;
#(
    parameter int FALLBACK_CYC = 15,
    parameter int TIMEOUT_CYC  = 19,
    parameter int HS_DLY_CYC   = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic od_n,
    input  logic supply_ok,
    input  logic sw_high,
    input  logic sw_below_1v,
    input  logic drvl_low,
    output logic drvh_en,
    output logic drvl_en
);

    logic [FLG_COUNT-1:0] flag_raw;
    logic [FLG_COUNT-1:0] flag_s;
    logic                 run_ok;
    logic                 hs_on;
    logic                 ls_on;

    assign flag_raw[FLG_SW_HIGH]  = sw_high;
    assign flag_raw[FLG_SW_BELOW] = sw_below_1v;
    assign flag_raw[FLG_GATE_LOW] = drvl_low;

    // One synchronizer per comparator flag.
    for (genvar gi = 0; gi < FLG_COUNT; gi++) begin : g_sync
        gdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (flag_raw[gi]),
            .q     (flag_s[gi])
        );
    end

    assign run_ok = od_n & supply_ok;

    gdt_fsm #(
        .FIX (FALLBACK_CYC),
        .TMO (TIMEOUT_CYC),
        .HSD (HS_DLY_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (run_ok),
        .pwm        (pwm_in),
        .sw_high_s  (flag_s[FLG_SW_HIGH]),
        .sw_below_s (flag_s[FLG_SW_BELOW]),
        .gate_low_s (flag_s[FLG_GATE_LOW]),
        .hs_on      (hs_on),
        .ls_on      (ls_on)
    );

    // Same-cycle forced-off gating of both enables.
    assign drvh_en = hs_on & run_ok;
    assign drvl_en = ls_on & run_ok;

endmodule

// File: rtl/gdt_checker.sv
// Temporal checks on the gate controller ports, bound to every instance.
// Assumes the timeout parameter matches the bound instance.
module gdt_checker #(
    parameter int TMO = 19
) (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic od_n,
    input logic supply_ok,
    input logic drvh_en,
    input logic drvl_en
);

    logic [15:0] wait_cnt;

    // Count consecutive enabled cycles with PWM low and no gate on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (od_n && supply_ok && !pwm_in && !drvh_en && !drvl_en) begin
            if (wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(drvh_en && drvl_en));

    p_od_forces_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !od_n |-> (!drvh_en && !drvl_en));

    p_uvlo_forces_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!drvh_en && !drvl_en));

    p_ls_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drvl_en) |-> ($past(!pwm_in) && $past(!drvh_en)));

    p_hs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drvh_en) |-> ($past(pwm_in) && $past(!drvl_en)));

    p_hs_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pwm_in) && $past(od_n && supply_ok)) |-> !drvh_en);

    p_ls_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwm_in) && $past(od_n && supply_ok)) |-> !drvl_en);

    p_ls_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= 16'(TMO + 2));

endmodule

bind gate_deadtime_ctrl gdt_checker #(.TMO(TIMEOUT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_in    (pwm_in),
    .od_n      (od_n),
    .supply_ok (supply_ok),
    .drvh_en   (drvh_en),
    .drvl_en   (drvl_en)
);

// File: tb/sim_gate_deadtime_ctrl.sv
// Self-checking bench: sweeps flag timing across each wait and measures
// the exact edge on which each enable first rises.
module sim_gate_deadtime_ctrl;

    localparam int FIX = 15;
    localparam int TMO = 19;
    localparam int HSD = 3;
    localparam int NEVER = 9999;
    localparam int WIN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic od_n = 1'b1;
    logic supply_ok = 1'b1;
    logic sw_high = 1'b0;
    logic sw_below_1v = 1'b0;
    logic drvl_low = 1'b1;
    logic drvh_en;
    logic drvl_en;

    int total = 0;
    int bad = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gate_deadtime_ctrl #(
        .FALLBACK_CYC (FIX),
        .TIMEOUT_CYC  (TMO),
        .HS_DLY_CYC   (HSD),
        .SYNC_STAGES  (2)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .pwm_in (pwm_in), .od_n (od_n),
        .supply_ok (supply_ok), .sw_high (sw_high),
        .sw_below_1v (sw_below_1v), .drvl_low (drvl_low),
        .drvh_en (drvh_en), .drvl_en (drvl_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Park in the high-side-on state; called and returns at a negedge.
    task automatic settle_hs();
        pwm_in = 1'b1; sw_high = 1'b0; sw_below_1v = 1'b0; drvl_low = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    // Park in the low-side-on state; called and returns at a negedge.
    task automatic settle_ls();
        pwm_in = 1'b0; sw_high = 1'b0; sw_below_1v = 1'b0; drvl_low = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    // Drive a per-edge schedule; report the first edge each enable is 1.
    task automatic trial(input bit pwm0, input int flip_at, input int hi_from,
                         input int hi_to, input int below_from, input int low_from,
                         output int lat_h, output int lat_l,
                         output bit h_at1, output bit l_at1);
        lat_h = 0; lat_l = 0; h_at1 = 1'b0; l_at1 = 1'b0;
        for (int i = 1; i <= WIN; i++) begin
            pwm_in      = (i < flip_at) ? pwm0 : !pwm0;
            sw_high     = (i >= hi_from) && (i < hi_to);
            sw_below_1v = (i >= below_from);
            drvl_low    = (i >= low_from);
            @(posedge clk);
            @(negedge clk);
            if (i == 1) begin h_at1 = drvh_en; l_at1 = drvl_en; end
            if (drvh_en && lat_h == 0) lat_h = i;
            if (drvl_en && lat_l == 0) lat_l = i;
            if (drvh_en && drvl_en) overlap++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int lh, ll, expv;
        bit h1, l1;

        // R10: reset holds both enables off.
        repeat (4) @(negedge clk);
        chk(!drvh_en && !drvl_en, "R10 reset outputs", {drvh_en, drvl_en}, 0);
        // R10: release with PWM low reaches the low side via the fallback.
        rst_n = 1'b1;
        trial(1'b0, NEVER, NEVER, NEVER, NEVER, 1, lh, ll, h1, l1);
        chk(ll == 1 + FIX, "R10 release to low side", ll, 1 + FIX);

        // R1: steady in-phase following.
        settle_hs();
        chk(drvh_en && !drvl_en, "R1 pwm high", {drvh_en, drvl_en}, 2);
        settle_ls();
        chk(!drvh_en && drvl_en, "R1 pwm low", {drvh_en, drvl_en}, 1);

        // R4 R6: node never rises -> fixed fallback.
        settle_hs();
        trial(1'b0, NEVER, NEVER, NEVER, NEVER, 0, lh, ll, h1, l1);
        chk(!h1, "R4 high drops at first edge", h1, 0);
        chk(ll == 1 + FIX, "R6 fallback edge", ll, 1 + FIX);

        // R6 R7: node rises at edge h, never falls -> fallback or timeout.
        for (int h = 1; h <= FIX + 1; h++) begin
            settle_hs();
            trial(1'b0, NEVER, h, h + 2, NEVER, 0, lh, ll, h1, l1);
            expv = (h <= FIX - 1) ? (1 + TMO) : (1 + FIX);
            chk(ll == expv, (h <= FIX - 1) ? "R7 timeout edge" : "R6 late rise fallback", ll, expv);
        end

        // R5: node seen high, below flag at edge b -> adaptive release.
        for (int b = 3; b <= TMO + 1; b++) begin
            settle_hs();
            trial(1'b0, NEVER, 1, 3, b, 0, lh, ll, h1, l1);
            expv = (b + 2 < 1 + TMO) ? (b + 2) : (1 + TMO);
            chk(ll == expv, "R5 adaptive edge", ll, expv);
        end

        // R8: low gate discharged flag at edge b -> high side after delay.
        for (int b = 1; b <= 8; b++) begin
            settle_ls();
            trial(1'b1, NEVER, NEVER, NEVER, NEVER, b, lh, ll, h1, l1);
            chk(!l1, "R8 low drops at first edge", l1, 0);
            chk(lh == b + 1 + HSD, "R8 high-side edge", lh, b + 1 + HSD);
        end

        // R11: PWM back high during the high-to-low wait.
        settle_hs();
        trial(1'b0, 5, NEVER, NEVER, NEVER, 0, lh, ll, h1, l1);
        chk(ll == 0, "R11 pending low never asserted", ll, 0);
        chk(lh == 5 + HSD, "R11 high resumes", lh, 5 + HSD);

        // R11: PWM back low during the low-to-high wait.
        settle_ls();
        trial(1'b1, 3, NEVER, NEVER, NEVER, NEVER, lh, ll, h1, l1);
        chk(lh == 0, "R11 pending high never asserted", lh, 0);
        chk(ll == 3 + FIX, "R11 low resumes", ll, 3 + FIX);

        // R2: output disable forces off in the same cycle, then recovery.
        settle_hs();
        od_n = 1'b0;
        #1;
        chk(!drvh_en && !drvl_en, "R2 immediate off", {drvh_en, drvl_en}, 0);
        repeat (3) @(negedge clk);
        chk(!drvh_en && !drvl_en, "R2 held off", {drvh_en, drvl_en}, 0);
        od_n = 1'b1;
        trial(1'b1, NEVER, NEVER, NEVER, NEVER, 0, lh, ll, h1, l1);
        chk(lh == 1 + HSD, "R10 disable release to high side", lh, 1 + HSD);

        // R3: lockout forces off and PWM has no effect while it lasts.
        settle_ls();
        supply_ok = 1'b0;
        #1;
        chk(!drvh_en && !drvl_en, "R3 immediate off", {drvh_en, drvl_en}, 0);
        for (int k = 0; k < 8; k++) begin
            pwm_in = k[0];
            @(negedge clk);
            chk(!drvh_en && !drvl_en, "R3 pwm ignored", {drvh_en, drvl_en}, 0);
        end
        supply_ok = 1'b1;
        trial(1'b0, NEVER, NEVER, NEVER, NEVER, 0, lh, ll, h1, l1);
        chk(ll == 1 + FIX, "R10 lockout release to low side", ll, 1 + FIX);

        // R9: no cycle ever had both enables on.
        chk(overlap == 0, "R9 overlap cycles", overlap, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule